// File: doc/BRIEF.md
# NRZ Transmit Serializer With Underrun Timeout

This block turns bytes written by a host into a serial non-return-to-zero bit stream, one bit per baud tick that comes from a baud generator outside the block. When the encoder is enabled and the line is idle, a data write starts transmission at once. There is no separate start command. Each written byte passes through a holding register into a shift register. A later byte that is already waiting moves into the shift register on the last tick of the current byte, so consecutive bytes are sent with no gap between them.

The block raises a one-cycle interrupt each time the holding register can take another byte: once when transmission starts and once more for every byte moved into the shift register. A status bit beside the interrupt tells a ready interrupt apart from an underrun interrupt. The host must write the next byte within a window of bit ticks after each ready indication. If it does not, the block stops transmitting, drives the line to its idle bias state, and raises the interrupt with the underrun status set. The holding and shift registers are not reset and hold no defined value until they are first loaded.

Top module: `nrz_tx_serializer`

## Requirements
- R1: After reset the line is idle: `txIdle`=1, `txOut`=0, `irq`=0 and `lastUnderrun`=0. Whenever `txIdle` is 1, `txOut` is 0.
- R2: A write (`wrValid`=1) while `enable`=1 and the line is idle starts transmission. In the next cycle `txIdle`=0 and `txOut` shows `wrData[7]`.
- R3: Bits go out first-in first-out in host order: `wrData[7]` first, down to `wrData[0]`. The output is non-inverting (a 1 is sent as `txOut`=1). It advances by one bit only on a cycle with `bitTick`=1, so after k ticks into a byte `txOut` equals bit 7-k of that byte.
- R4: A ready interrupt is one cycle of `irq`=1 with `lastUnderrun`=0. It appears in the cycle after transmission starts and in the cycle after each byte is moved from the holding register to the shift register. Writes into the holding register raise no interrupt.
- R5: A byte waiting in the holding register enters the shift register on the 8th tick of the current byte, so its bit 7 is on `txOut` right after that tick with no idle bit between the bytes.
- R6: If the holding register is still empty at the 7th bit tick after the last ready indication, and no write arrives in that cycle, transmission ends. In the next cycle `txIdle`=1, `txOut`=0, and `irq`=1 with `lastUnderrun`=1.
- R7: A write clears the underrun window. A write in the same cycle as the 7th tick prevents the underrun, and that byte follows on the 8th tick.
- R8: While `enable`=0, writes are ignored and the line stays idle. Dropping `enable` during transmission makes the line idle in the next cycle and raises no interrupt.
- R9: A second write while the holding register is already full replaces the waiting byte. Only the later byte is transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Encoder enable |
| bitTick | input | 1 | One-cycle baud tick, one per bit period |
| wrValid | input | 1 | Host data write strobe |
| wrData | input | 8 | Byte to transmit; bit 7 is sent first |
| txOut | output | 1 | Serial data level, 0 while idle |
| txIdle | output | 1 | Line held at idle bias level |
| irq | output | 1 | One-cycle interrupt pulse |
| lastUnderrun | output | 1 | Cause of the latest interrupt: 1 = underrun, 0 = buffer ready |

## Verification
The assertions check on every cycle the relations between the ports:
- the line is low whenever it is idle;
- a write to an idle, enabled encoder starts transmission and raises a ready interrupt;
- a low enable forces idle with no interrupt;
- the data level holds between ticks;
- an underrun interrupt always comes with an idle line.

Only the bench scenarios can show behaviour that depends on the byte content and on tick counting. This covers the bit order of each byte, the seamless hand-off on the 8th tick, the exact tick on which the underrun window closes, the effect of a write that lands on that tick, and the overwrite of a waiting byte.

// File: rtl/nrz_tx_pkg.sv
package nrz_tx_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadFromIn;    // shift register takes the byte on the write port
    logic loadFromHold;  // shift register takes the waiting byte
    logic shift;         // advance one bit
    logic writeHold;     // holding register takes the write port
  } txStrobes_t;

endpackage

// File: rtl/nrz_tx_datapath.sv
module nrz_tx_datapath
  import nrz_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic              txBit
);

  // Data registers are intentionally left without reset
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (strobes.writeHold) holdReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobes.loadFromHold)    shiftReg <= holdReg;
    else if (strobes.loadFromIn) shiftReg <= wrData;
    else if (strobes.shift)      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
  end

  assign txBit = shiftReg[DATA_W-1];

endmodule

// File: rtl/nrz_tx_control.sv
module nrz_tx_control
  import nrz_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TIMEOUT_TICKS = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       bitTick,
  input  logic       wrValid,
  output txStrobes_t strobes,
  output logic       active,
  output logic       irq,
  output logic       lastUnderrun
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam int TMO_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_TICKS - 1);

  logic             holdFull;
  logic [CNT_W-1:0] bitCnt;
  logic [TMO_W-1:0] tmoCnt;

  logic wrEn, startEvt, lastTick, timeoutHit, terminate, readyEvt;
  logic directLoad;

  always_comb begin
    wrEn       = wrValid & enable;
    startEvt   = wrEn & ~active;
    lastTick   = enable & active & bitTick & (bitCnt == LAST_BIT);
    directLoad = lastTick & ~holdFull & wrEn;
    timeoutHit = enable & active & bitTick & ~holdFull & ~wrEn & (tmoCnt == TMO_LAST);
    terminate  = timeoutHit | (lastTick & ~holdFull & ~wrEn);
    readyEvt   = startEvt | (lastTick & (holdFull | wrEn));

    strobes.loadFromIn   = startEvt | directLoad;
    strobes.loadFromHold = lastTick & holdFull;
    strobes.shift        = enable & active & bitTick & ~lastTick;
    strobes.writeHold    = wrEn & active & ~directLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
    end else if (!enable || terminate) begin
      active <= 1'b0;
    end else if (startEvt) begin
      active <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
    end else if (!enable || startEvt || terminate) begin
      holdFull <= 1'b0;
    end else if (lastTick) begin
      holdFull <= holdFull & wrEn;
    end else if (strobes.writeHold) begin
      holdFull <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (startEvt || lastTick) begin
      bitCnt <= '0;
    end else if (strobes.shift) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoCnt <= '0;
    end else if (readyEvt || wrEn || terminate || !enable) begin
      tmoCnt <= '0;
    end else if (active && bitTick && !holdFull) begin
      tmoCnt <= tmoCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq          <= 1'b0;
      lastUnderrun <= 1'b0;
    end else begin
      irq <= readyEvt | terminate;
      if (terminate)     lastUnderrun <= 1'b1;
      else if (readyEvt) lastUnderrun <= 1'b0;
    end
  end

endmodule

// File: rtl/nrz_tx_serializer.sv
module nrz_tx_serializer
  import nrz_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TIMEOUT_TICKS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bitTick,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              txOut,
  output logic              txIdle,
  output logic              irq,
  output logic              lastUnderrun
);

  txStrobes_t strobes;
  logic       active;
  logic       txBit;

  nrz_tx_control #(
    .DATA_W       (DATA_W),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .bitTick     (bitTick),
    .wrValid     (wrValid),
    .strobes     (strobes),
    .active      (active),
    .irq         (irq),
    .lastUnderrun(lastUnderrun)
  );

  nrz_tx_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .strobes(strobes),
    .wrData (wrData),
    .txBit  (txBit)
  );

  assign txOut  = active & txBit;
  assign txIdle = ~active;

endmodule

// File: rtl/nrz_tx_checker.sv
module nrz_tx_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic bitTick,
  input logic wrValid,
  input logic txOut,
  input logic txIdle,
  input logic irq,
  input logic lastUnderrun
);

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> !txOut);

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrValid && txIdle) |=> !txIdle);

  p_start_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrValid && txIdle) |=> (irq && !lastUnderrun));

  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !txIdle) |=> (txIdle || $stable(txOut)));

  p_underrun_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irq && lastUnderrun) |-> txIdle);

  p_disable_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txIdle && !irq));

endmodule

bind nrz_tx_serializer nrz_tx_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .bitTick     (bitTick),
  .wrValid     (wrValid),
  .txOut       (txOut),
  .txIdle      (txIdle),
  .irq         (irq),
  .lastUnderrun(lastUnderrun)
);

// File: tb/sim_nrz_tx_serializer.sv
module sim_nrz_tx_serializer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       bitTick = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       txOut, txIdle, irq, lastUnderrun;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nrz_tx_serializer u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick),
    .wrValid(wrValid), .wrData(wrData), .txOut(txOut), .txIdle(txIdle),
    .irq(irq), .lastUnderrun(lastUnderrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // Called at a negedge; one posedge passes before it returns at a negedge
  task automatic step(input logic tick, input logic wr, input logic [7:0] d);
    bitTick = tick; wrValid = wr; wrData = d;
    @(negedge clk);
    bitTick = 1'b0; wrValid = 1'b0;
  endtask

  // Ticks k=fromK..toK within a byte, checking bit 7-k each time
  task automatic tickBits(input logic [7:0] d, input int fromK, input int toK);
    for (int k = fromK; k <= toK; k++) begin
      step(1'b1, 1'b0, 8'h00);
      checkEq("R3 bit order", txOut, d[7-k]);
      checkEq("R4 no irq mid byte", irq, 0);
      checkEq("R3 still active", txIdle, 0);
    end
  endtask

  task automatic expectUnderrun();
    step(1'b1, 1'b0, 8'h00);           // 7th tick since ready
    checkEq("R6 idle after timeout", txIdle, 1);
    checkEq("R6 line low", txOut, 0);
    checkEq("R6 irq", irq, 1);
    checkEq("R6 underrun cause", lastUnderrun, 1);
    step(1'b0, 1'b0, 8'h00);
    checkEq("R6 irq single pulse", irq, 0);
  endtask

  task automatic startByte(input logic [7:0] d);
    step(1'b0, 1'b1, d);
    checkEq("R2 active after start", txIdle, 0);
    checkEq("R2 first bit", txOut, d[7]);
    checkEq("R4 ready irq on start", irq, 1);
    checkEq("R4 ready cause", lastUnderrun, 0);
  endtask

  task automatic testReset();
    checkEq("R1 reset idle", txIdle, 1);
    checkEq("R1 reset line", txOut, 0);
    checkEq("R1 reset irq", irq, 0);
    checkEq("R1 reset cause", lastUnderrun, 0);
  endtask

  task automatic testSingleByte();
    startByte(8'hA5);
    step(1'b0, 1'b0, 8'h00);
    checkEq("R3 no advance without tick", txOut, 1);
    tickBits(8'hA5, 1, 6);
    expectUnderrun();
  endtask

  task automatic testBackToBack();
    startByte(8'h3C);
    tickBits(8'h3C, 1, 2);
    step(1'b0, 1'b1, 8'hC3);
    checkEq("R4 no irq on hold write", irq, 0);
    tickBits(8'h3C, 3, 7);                 // 7th tick passes: hold is full
    step(1'b1, 1'b0, 8'h00);               // 8th tick
    checkEq("R5 seamless next byte", txOut, 1);
    checkEq("R5 still active", txIdle, 0);
    checkEq("R4 ready irq on reload", irq, 1);
    checkEq("R4 reload cause", lastUnderrun, 0);
    tickBits(8'hC3, 1, 6);
    expectUnderrun();
  endtask

  task automatic testLateWrite();
    startByte(8'h5A);
    tickBits(8'h5A, 1, 6);
    step(1'b1, 1'b1, 8'h81);               // write on the 7th tick
    checkEq("R7 no underrun on coincident write", txIdle, 0);
    checkEq("R7 no irq", irq, 0);
    checkEq("R7 last bit of byte", txOut, 0);
    step(1'b1, 1'b0, 8'h00);
    checkEq("R7 late byte follows", txOut, 1);
    checkEq("R7 ready irq", irq, 1);
    tickBits(8'h81, 1, 6);
    expectUnderrun();
  endtask

  task automatic testOverwrite();
    startByte(8'h00);
    step(1'b0, 1'b1, 8'hF0);
    step(1'b0, 1'b1, 8'h0F);
    tickBits(8'h00, 1, 7);
    step(1'b1, 1'b0, 8'h00);
    checkEq("R9 later byte sent", txOut, 0);
    checkEq("R9 reload irq", irq, 1);
    tickBits(8'h0F, 1, 6);
    expectUnderrun();
  endtask

  task automatic testDisable();
    enable = 1'b0;
    step(1'b0, 1'b1, 8'hFF);
    checkEq("R8 write ignored idle", txIdle, 1);
    checkEq("R8 no irq when disabled", irq, 0);
    checkEq("R8 line low", txOut, 0);
    enable = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    checkEq("R8 stays idle after enable", txIdle, 1);
    startByte(8'hFF);
    tickBits(8'hFF, 1, 2);
    enable = 1'b0;
    step(1'b0, 1'b0, 8'h00);
    checkEq("R8 stop on disable", txIdle, 1);
    checkEq("R8 no irq on disable", irq, 0);
    checkEq("R8 line low on disable", txOut, 0);
    enable = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    checkEq("R8 no irq later", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisable();
    enable = 1'b1;
    testSingleByte();
    testBackToBack();
    testLateWrite();
    testOverwrite();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule